// File: doc/BRIEF.md
# SDRAM Bank State Timing Monitor

This block sits on a DDR2-style command bus and only watches it. On every clock it decodes the command from the chip-select, RAS, CAS and WE strobes. It tracks whether each of four banks is idle, active, waiting for an auto-precharge or precharging. It stores the row opened in each bank. Per-bank counters measure the time since the last activate and the time since a precharge began. A shared counter measures the time between activates to different banks.

When a command breaks a spacing or state rule, a sticky error flag is raised. A 3-bit code names the first rule that was broken. Later violations leave the flag and code unchanged until a synchronous reset. All timing limits are parameters counted in clocks. The burst length is a parameter with default 4. A column command with auto-precharge therefore starts its precharge two clocks after the command.

Each bank runs a four-state machine:
- IDLE goes to ACTIVE on an activate.
- ACTIVE goes to AP_PEND on a read or write with A10 high.
- ACTIVE goes to PRECHG on an explicit precharge.
- AP_PEND goes to PRECHG when the half-burst delay has run out.
- PRECHG goes to IDLE once tRP has been counted.
- An activate in any state forces ACTIVE.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Commands are decoded only when cs_n is 0, from {ras_n,cas_n,we_n}: 011 is activate, 101 is read, 100 is write, and 010 is precharge. With cs_n 1, or with any other strobe pattern, nothing changes.
- R2: After synchronous reset (rst high), bank_open is 0, err_flag is 0 and err_code is 0.
- R3: An activate sets bit ba of bank_open in the next cycle. It stores addr in bank_rows[ba*13 +: 13].
- R4: A read or write with addr[10] low leaves its bank open.
- R5: A read or write to a bank that is not ACTIVE raises error code 1.
- R6: An activate to a bank that is ACTIVE raises code 2.
- R7: An activate fewer than T_RC clocks after the previous activate to the same bank raises code 3.
- R8: An activate to a different bank fewer than T_RRD clocks after the last activate raises code 4. Exactly T_RRD clocks apart is legal.
- R9: An activate to a bank in AP_PEND or PRECHG raises code 5. After an explicit precharge at cycle p, the bank is in PRECHG until cycle p+T_RP.
- R10: A precharge to an ACTIVE bank fewer than T_RAS clocks after its activate raises code 6. The bank closes anyway.
- R11: A read or write with addr[10] high clears the bank's open bit in the next cycle. Its precharge begins BURST_LEN/2 clocks after the command, and an activate becomes legal T_RP clocks after that.
- R12: A precharge with addr[10] high closes every bank and checks each active bank for tRAS. A precharge to an idle bank has no effect.
- R13: err_flag is sticky and err_code keeps the first code until reset. For one activate, the codes rank 2 over 5 over 3 over 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row address or column address; bit 10 is the precharge-all / auto-precharge flag |
| bank_open | output | 4 | One bit per bank, set while the bank is ACTIVE |
| bank_rows | output | 52 | Stored row of each bank, 13 bits per bank, bank 0 lowest |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violated rule (0 means none) |

## Verification
The bench builds the monitor with T_RAS=5, T_RP=3, T_RC=11 and T_RRD=2. With these values, T_RC is larger than T_RAS+T_RP. This lets a re-activate that satisfies tRP still break tRC, so the tRC and tRP codes can each be reached on their own. The short windows place each legal boundary and its one-cycle-early violation only a few clocks apart. Every limit, including the auto-precharge delay followed by tRP, can therefore be probed at both edges in short sequences.

// File: rtl/smon_pkg.sv
package smon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_AP_PEND = 2'd2,
        BK_PRECHG  = 2'd3
    } bank_st_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_COL_CLOSED = 3'd1,
        ERR_ACT_OPEN   = 3'd2,
        ERR_TRC        = 3'd3,
        ERR_TRRD       = 3'd4,
        ERR_TRP        = 3'd5,
        ERR_TRAS       = 3'd6
    } err_e;

endpackage

// File: rtl/smon_cmd_decode.sv
module smon_cmd_decode
    import smon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/smon_act_spacing.sv
module smon_act_spacing #(
    parameter int BANK_W = 2,
    parameter int T_RRD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_fire,
    input  logic [BANK_W-1:0] bank,
    output logic              err_o
);

    localparam int CW = $clog2(T_RRD + 1);
    localparam logic [CW-1:0] CMAX = CW'(T_RRD);

    logic [CW-1:0]     cnt_q;
    logic [BANK_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CMAX;
            last_q <= '0;
        end else if (act_fire) begin
            cnt_q  <= CW'(1);
            last_q <= bank;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        err_o = act_fire && (cnt_q < CMAX) && (bank != last_q);
    end

endmodule

// File: rtl/smon_bank_fsm.sv
module smon_bank_fsm
    import smon_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int T_RC     = 14,
    parameter int T_RAS    = 8,
    parameter int T_RP     = 3,
    parameter int AP_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  cmd_e             cmd,
    input  logic             ap,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output err_e             err_o
);

    localparam int CNT_MAX = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int TMR_MAX = (T_RP > AP_DELAY) ? T_RP : AP_DELAY;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [CNT_W-1:0] CSAT = CNT_W'(CNT_MAX);

    bank_st_e         st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [TMR_W-1:0] tmr_q, tmr_n;
    logic [ROW_W-1:0] row_q, row_n;
    logic             is_col;

    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= CSAT;
            tmr_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            tmr_q <= tmr_n;
            row_q <= row_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st_q;
        tmr_n = tmr_q;
        row_n = row_q;
        cnt_n = (cnt_q == CSAT) ? cnt_q : cnt_q + CNT_W'(1);
        unique case (st_q)
            BK_IDLE:   ;
            BK_ACTIVE: ;
            BK_AP_PEND: begin
                if (tmr_q == '0) begin
                    if (T_RP <= 1) st_n = BK_IDLE;
                    else begin
                        st_n  = BK_PRECHG;
                        tmr_n = TMR_W'(T_RP - 1);
                    end
                end else begin
                    tmr_n = tmr_q - TMR_W'(1);
                end
            end
            BK_PRECHG: begin
                if (tmr_q <= TMR_W'(1)) st_n = BK_IDLE;
                else                    tmr_n = tmr_q - TMR_W'(1);
            end
            default: st_n = BK_IDLE;
        endcase
        if (hit) begin
            if (cmd == CMD_ACT) begin
                st_n  = BK_ACTIVE;
                row_n = row_in;
                cnt_n = CNT_W'(1);
            end else if (is_col && ap && st_q == BK_ACTIVE) begin
                st_n  = BK_AP_PEND;
                tmr_n = TMR_W'(AP_DELAY - 1);
            end else if (cmd == CMD_PRE && st_q == BK_ACTIVE) begin
                if (T_RP <= 1) st_n = BK_IDLE;
                else begin
                    st_n  = BK_PRECHG;
                    tmr_n = TMR_W'(T_RP - 1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        open_o = (st_q == BK_ACTIVE);
        row_o  = row_q;
        err_o  = ERR_NONE;
        if (hit) begin
            if (cmd == CMD_ACT) begin
                if (st_q == BK_ACTIVE)
                    err_o = ERR_ACT_OPEN;
                else if (st_q == BK_AP_PEND || st_q == BK_PRECHG)
                    err_o = ERR_TRP;
                else if (cnt_q < CNT_W'(T_RC))
                    err_o = ERR_TRC;
            end else if (is_col) begin
                if (st_q != BK_ACTIVE) err_o = ERR_COL_CLOSED;
            end else if (cmd == CMD_PRE) begin
                if (st_q == BK_ACTIVE && cnt_q < CNT_W'(T_RAS)) err_o = ERR_TRAS;
            end
        end
    end

    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd == CMD_ACT) |=> open_o);

    p_row_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd == CMD_ACT) |=> (row_o == $past(row_in)));

    p_ap_closes_r11: assert property (@(posedge clk) disable iff (rst)
        (hit && is_col && ap && open_o) |=> !open_o);

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import smon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int T_RC      = 14,
    parameter int T_RAS     = 8,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BANK_W-1:0]           ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_rows,
    output logic                        err_flag,
    output logic [2:0]                  err_code
);

    localparam int AP_DELAY = BURST_LEN / 2;

    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] hit;
    err_e                 bank_err [NUM_BANKS];
    logic                 rrd_err;
    err_e                 cur_err;
    logic                 flag_q;
    err_e                 code_q;

    smon_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    smon_act_spacing #(.BANK_W(BANK_W), .T_RRD(T_RRD)) u_rrd (
        .clk      (clk),
        .rst      (rst),
        .act_fire (cmd == CMD_ACT),
        .bank     (ba),
        .err_o    (rrd_err)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign hit[i] = (ba == BANK_W'(i)) || (cmd == CMD_PRE && addr[AP_BIT]);
        smon_bank_fsm #(
            .ROW_W    (ADDR_W),
            .T_RC     (T_RC),
            .T_RAS    (T_RAS),
            .T_RP     (T_RP),
            .AP_DELAY (AP_DELAY)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .hit    (hit[i]),
            .cmd    (cmd),
            .ap     (addr[AP_BIT]),
            .row_in (addr),
            .open_o (bank_open[i]),
            .row_o  (bank_rows[i*ADDR_W +: ADDR_W]),
            .err_o  (bank_err[i])
        );
    end

    always_comb begin
        cur_err = ERR_NONE;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_err[i] != ERR_NONE) cur_err = bank_err[i];
        end
        if (cur_err == ERR_NONE && rrd_err) cur_err = ERR_TRRD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            code_q <= ERR_NONE;
        end else if (!flag_q && cur_err != ERR_NONE) begin
            flag_q <= 1'b1;
            code_q <= cur_err;
        end
    end

    assign err_flag = flag_q;
    assign err_code = code_q;

    p_reset_r2: assert property (@(posedge clk)
        rst |=> (!err_flag && err_code == 3'd0 && bank_open == '0));

    p_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> (err_flag && $stable(err_code)));

    p_desel_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(bank_open));

    p_preall_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && addr[AP_BIT]) |=> (bank_open == '0));

endmodule

// File: tb/sim_sdram_bank_monitor.sv
module sim_sdram_bank_monitor;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_DES = 4'b1111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  bank_open;
    logic [51:0] bank_rows;
    logic        err_flag;
    logic [2:0]  err_code;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        bit         chk;
        logic [3:0] open;
        logic       err;
        logic [2:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    sdram_bank_monitor #(
        .T_RC(11), .T_RAS(5), .T_RP(3), .T_RRD(2)
    ) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
        .bank_rows(bank_rows), .err_flag(err_flag), .err_code(err_code)
    );

    always #10 clk = ~clk;

    // monitor: compares one expected item per clock
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                if (it.chk) begin
                    n_chk++;
                    if (bank_open !== it.open || err_flag !== it.err || err_code !== it.code) begin
                        n_bad++;
                        $display("FAIL %s: open=%b err=%b code=%0d expected open=%b err=%b code=%0d",
                                 it.tag, bank_open, err_flag, err_code, it.open, it.err, it.code);
                    end
                end
            end
        end
    end

    task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                        input bit chk, input logic [3:0] eo, input logic ee,
                        input logic [2:0] ec, input string tag);
        exp_t it;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
        it.chk = chk; it.open = eo; it.err = ee; it.code = ec; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(C_DES, 2'd0, 13'd0, 1'b0, 4'd0, 1'b0, 3'd0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_DES;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_row(input int b, input logic [12:0] ev, input string tag);
        #2;
        n_chk++;
        if (bank_rows[b*13 +: 13] !== ev) begin
            n_bad++;
            $display("FAIL %s: row=%h expected %h", tag, bank_rows[b*13 +: 13], ev);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

    initial begin
        // R2 reset state
        do_reset();
        step(C_DES, 2'd0, 13'd0, 1, 4'b0000, 0, 3'd0, "R2 reset");

        // legal flow: R3 R4 R8 boundary, R10 boundary, R7 boundary
        do_reset();
        step(C_ACT, 2'd0, 13'h123, 1, 4'b0001, 0, 3'd0, "R3 activate b0");
        idle(1);
        step(C_ACT, 2'd1, 13'h0AB, 1, 4'b0011, 0, 3'd0, "R8 spacing equal tRRD");
        check_row(0, 13'h123, "R3 row b0");
        check_row(1, 13'h0AB, "R3 row b1");
        step(C_RD, 2'd0, 13'h010, 1, 4'b0011, 0, 3'd0, "R4 read no ap");
        step(C_WR, 2'd1, 13'h020, 1, 4'b0011, 0, 3'd0, "R4 write no ap");
        step(C_PRE, 2'd0, 13'h000, 1, 4'b0010, 0, 3'd0, "R10 precharge at tRAS");
        idle(5);
        step(C_ACT, 2'd0, 13'h1FF, 1, 4'b0011, 0, 3'd0, "R7 re-activate at tRC");
        check_row(0, 13'h1FF, "R3 row b0 updated");

        // R7 tRC violation
        do_reset();
        step(C_ACT, 2'd0, 13'h5, 0, 4'd0, 0, 3'd0, "");
        idle(4);
        step(C_PRE, 2'd0, 13'h0, 0, 4'd0, 0, 3'd0, "");
        idle(2);
        step(C_ACT, 2'd0, 13'h6, 1, 4'b0001, 1, 3'd3, "R7 tRC short");

        // R9 tRP violation after explicit precharge
        do_reset();
        step(C_ACT, 2'd0, 13'h5, 0, 4'd0, 0, 3'd0, "");
        idle(9);
        step(C_PRE, 2'd0, 13'h0, 0, 4'd0, 0, 3'd0, "");
        idle(1);
        step(C_ACT, 2'd0, 13'h6, 1, 4'b0001, 1, 3'd5, "R9 tRP short");

        // R13 priority: tRP over tRC
        do_reset();
        step(C_ACT, 2'd0, 13'h5, 0, 4'd0, 0, 3'd0, "");
        idle(4);
        step(C_PRE, 2'd0, 13'h0, 0, 4'd0, 0, 3'd0, "");
        step(C_ACT, 2'd0, 13'h6, 1, 4'b0001, 1, 3'd5, "R13 tRP ranks over tRC");

        // R10 tRAS violation
        do_reset();
        step(C_ACT, 2'd2, 13'h7, 0, 4'd0, 0, 3'd0, "");
        idle(2);
        step(C_PRE, 2'd2, 13'h0, 1, 4'b0000, 1, 3'd6, "R10 tRAS short");

        // R6 activate to open bank (also ranks over tRC)
        do_reset();
        step(C_ACT, 2'd1, 13'h7, 0, 4'd0, 0, 3'd0, "");
        step(C_ACT, 2'd1, 13'h8, 1, 4'b0010, 1, 3'd2, "R6 activate open bank");

        // R5 read closed, then R13 sticky
        do_reset();
        step(C_RD, 2'd3, 13'h0, 1, 4'b0000, 1, 3'd1, "R5 read closed bank");
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        idle(1);
        step(C_ACT, 2'd0, 13'h2, 1, 4'b0001, 1, 3'd1, "R13 sticky first code");

        // R5 write closed
        do_reset();
        step(C_WR, 2'd2, 13'h0, 1, 4'b0000, 1, 3'd1, "R5 write closed bank");

        // R8 tRRD violation
        do_reset();
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        step(C_ACT, 2'd1, 13'h2, 1, 4'b0011, 1, 3'd4, "R8 tRRD short");

        // R11 auto-precharge, activate one cycle early
        do_reset();
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        idle(9);
        step(C_RD, 2'd0, 13'h400, 1, 4'b0000, 0, 3'd0, "R11 read ap closes");
        idle(3);
        step(C_ACT, 2'd0, 13'h2, 1, 4'b0001, 1, 3'd5, "R11 activate before ap+tRP");

        // R11 auto-precharge boundary, write variant
        do_reset();
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        idle(9);
        step(C_WR, 2'd0, 13'h400, 1, 4'b0000, 0, 3'd0, "R11 write ap closes");
        idle(4);
        step(C_ACT, 2'd0, 13'h2, 1, 4'b0001, 0, 3'd0, "R11 activate at ap+tRP");

        // R4 write keeps bank 3 open
        do_reset();
        step(C_ACT, 2'd3, 13'h9, 0, 4'd0, 0, 3'd0, "");
        step(C_WR, 2'd3, 13'h004, 1, 4'b1000, 0, 3'd0, "R4 write keeps b3 open");

        // R12 precharge all legal, then precharge idle bank
        do_reset();
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        idle(1);
        step(C_ACT, 2'd2, 13'h2, 0, 4'd0, 0, 3'd0, "");
        idle(7);
        step(C_PRE, 2'd3, 13'h400, 1, 4'b0000, 0, 3'd0, "R12 precharge all");
        step(C_PRE, 2'd1, 13'h000, 1, 4'b0000, 0, 3'd0, "R12 precharge idle bank");

        // R12 precharge all with one bank short of tRAS
        do_reset();
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        idle(1);
        step(C_ACT, 2'd1, 13'h2, 0, 4'd0, 0, 3'd0, "");
        idle(3);
        step(C_PRE, 2'd0, 13'h400, 1, 4'b0000, 1, 3'd6, "R12 precharge all tRAS");

        // R1 deselected and unsupported patterns ignored
        do_reset();
        step(C_ACT, 2'd0, 13'h1, 0, 4'd0, 0, 3'd0, "");
        step(4'b1011, 2'd0, 13'h2, 1, 4'b0001, 0, 3'd0, "R1 cs high activate ignored");
        step(4'b0001, 2'd0, 13'h0, 1, 4'b0001, 0, 3'd0, "R1 other pattern ignored");
        step(4'b1010, 2'd0, 13'h400, 1, 4'b0001, 0, 3'd0, "R1 cs high precharge ignored");
        check_row(0, 13'h001, "R1 row unchanged");

        idle(2);
        wait (exp_q.size() == 0);
        #5;
        finish_run();
    end

endmodule